// File: doc/BRIEF.md
# Direct-Mapped Read-Only Cache with Queued Miss Servicing

This block is a small direct-mapped read-only cache placed between a client that issues word reads and a slower external memory. Lookup is done by a controller in ordinary logic. The controller reads a tag RAM and a data RAM, and it keeps a register of per-line valid flags. When a lookup misses, the controller does not refill the line itself. It sends the line address through a request queue to a separate fill engine. The fill engine fetches the whole line from external memory, word by word, and writes it into the data RAM. It then reports completion through an acknowledge queue.

The client offers one read at a time on a valid/ready handshake and receives one response pulse carrying the data. On a miss the client is held off, with ready low, until the line has been filled. The controller then installs the tag, sets the valid flag and repeats the lookup, which now hits. Only one miss can be outstanding at any time. Addresses are word addresses. The line geometry (number of lines, words per line) and the address and data widths are parameters.

Top module: `ro_cache`

## Requirements
- R1: After reset the block shows `req_ready` high, `rsp_valid` low and `mem_req` low.
- R2: A word address splits as follows. The low log2(WORDS) bits are the word offset. The next log2(LINES) bits are the line index. The remaining upper bits are the tag. Two addresses hit the same cached line only if index and tag both match.
- R3: A read that hits is answered with `rsp_valid` high and the correct data in the clock cycle right after the request is accepted.
- R4: On a miss the client is stalled: `req_ready` stays low from acceptance until the response, and no response is given before the line has been filled.
- R5: For a miss, the fill engine reads every word of the missing line from external memory, offsets 0 to WORDS-1 in ascending order. It holds each `mem_req` and `mem_addr` steady until `mem_ack` returns that word.
- R6: The response after a fill carries the word that external memory holds at the requested address.
- R7: A line holds one tag at a time. An access with the same index but a different tag misses and replaces the line, so the old tag misses afterwards.
- R8: At most one miss is outstanding. External memory is requested only while the client is stalled.
- R9: Reset clears every valid flag, so the first access to each line after reset is a miss.
- R10: Each accepted request produces exactly one single-cycle `rsp_valid` pulse, and `req_ready` returns high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client read request valid |
| req_addr | input | ADDR_W | Client word address |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | Read data valid (single-cycle pulse) |
| rsp_data | output | DATA_W | Read data |
| mem_req | output | 1 | Fill engine word read request, held until acknowledged |
| mem_addr | output | ADDR_W | Word address read from external memory |
| mem_ack | input | 1 | External memory returns the requested word this cycle |
| mem_rdata | input | DATA_W | Word returned by external memory |

## Verification
The assertions assume that external memory raises `mem_ack` only while `mem_req` is high and keeps the data tied to the address currently requested. They also assume that `req_addr` is stable while `req_valid` waits for `req_ready`. The bench's memory model acknowledges a held request after a random delay of zero to three cycles. The bench drives client requests only on falling edges and holds them until they are accepted. The random reads use only four tag values across all indices and offsets. This makes hits, cold misses and conflict replacements all frequent.

// File: rtl/rc_pkg.sv
// Package rc_pkg
// Shared state encodings for the read-only cache controller and fill engine.
package rc_pkg;

    // Lookup controller states
    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,  // ready for a client request
        CS_LOOK   = 2'd1,  // RAM outputs valid, compare tag
        CS_WAIT   = 2'd2,  // miss queued, waiting for fill acknowledge
        CS_REPLAY = 2'd3   // tag installed, re-read arrays
    } ctrl_state_t;

    // Fill engine states
    typedef enum logic {
        FS_IDLE = 1'b0,    // waiting for a queued miss
        FS_RUN  = 1'b1     // fetching words of one line
    } fill_state_t;

endpackage

// File: rtl/rc_fifo.sv
// Module rc_fifo
// Synchronous FIFO used to decouple the lookup controller from the fill engine.
// Assumes DEPTH is a power of two and callers never push when full nor pop
// when empty. Output shows the head entry combinationally.
module rc_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W:0]   wr_ptr;
    logic [PTR_W:0]   rd_ptr;

    // Pointer update on push and pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr[PTR_W-1:0]] <= din;
    end

    // Status and head output
    always_comb begin
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
        dout  = store[rd_ptr[PTR_W-1:0]];
    end

endmodule

// File: rtl/rc_ram.sv
// Module rc_ram
// Simple dual-port on-chip RAM: one synchronous write port and one synchronous
// read port. Read data appears one cycle after the read address. Contents are
// not reset; validity is tracked outside.
module rc_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rc_ctrl.sv
// Module rc_ctrl
// Lookup controller. It accepts one client read at a time, reads the tag and
// data RAMs, and decides hit or miss against the valid flags. On a miss it
// queues the line address for the fill engine and stalls. When the acknowledge
// arrives it installs the tag and valid flag from the acknowledge payload and
// replays the lookup. Assumes the fill engine writes the data RAM before it
// acknowledges.
module rc_ctrl
    import rc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int WORDS  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        req_ready,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_data,
    // miss queue toward fill engine
    output logic                        miss_push,
    output logic [ADDR_W-$clog2(WORDS)-1:0] miss_line,
    // acknowledge queue from fill engine
    input  logic                        ack_empty,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] ack_line,
    output logic                        ack_pop,
    // data RAM read port
    output logic [$clog2(LINES*WORDS)-1:0] dram_raddr,
    input  logic [DATA_W-1:0]           dram_rdata
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = ADDR_W - OFF_W;

    ctrl_state_t      state, state_nx;
    logic [ADDR_W-1:0] held_addr;
    logic [LINES-1:0]  valid_q;
    logic [IDX_W-1:0]  rd_idx;
    logic [OFF_W-1:0]  rd_off;
    logic [TAG_W-1:0]  tag_rdata;
    logic              tag_we;
    logic [IDX_W-1:0]  tag_widx;
    logic [TAG_W-1:0]  tag_wdata;
    logic [IDX_W-1:0]  held_idx;
    logic [TAG_W-1:0]  held_tag;
    logic              hit;
    logic              accept;

    assign held_idx = held_addr[OFF_W +: IDX_W];
    assign held_tag = held_addr[ADDR_W-1 -: TAG_W];

    // Tag storage in on-chip RAM
    rc_ram #(.WIDTH(TAG_W), .DEPTH(LINES)) u_tag_ram (
        .clk   (clk),
        .we    (tag_we),
        .waddr (tag_widx),
        .wdata (tag_wdata),
        .raddr (rd_idx),
        .rdata (tag_rdata)
    );

    // Array read address: live request when idle, held request otherwise
    always_comb begin
        if (state == CS_IDLE) begin
            rd_idx = req_addr[OFF_W +: IDX_W];
            rd_off = req_addr[OFF_W-1:0];
        end else begin
            rd_idx = held_idx;
            rd_off = held_addr[OFF_W-1:0];
        end
        dram_raddr = {rd_idx, rd_off};
    end

    // Hit detection and client-facing outputs
    always_comb begin
        req_ready = (state == CS_IDLE);
        accept    = req_valid && req_ready;
        hit       = (state == CS_LOOK) && valid_q[held_idx] && (tag_rdata == held_tag);
        rsp_valid = hit;
        rsp_data  = dram_rdata;
    end

    // Queue handshakes and tag install
    always_comb begin
        miss_push = (state == CS_LOOK) && !hit;
        miss_line = held_addr[ADDR_W-1:OFF_W];
        ack_pop   = (state == CS_WAIT) && !ack_empty;
        tag_we    = ack_pop;
        tag_widx  = ack_line[IDX_W-1:0];
        tag_wdata = ack_line[LINE_W-1 -: TAG_W];
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            CS_IDLE:   if (accept) state_nx = CS_LOOK;
            CS_LOOK:   state_nx = hit ? CS_IDLE : CS_WAIT;
            CS_WAIT:   if (!ack_empty) state_nx = CS_REPLAY;
            CS_REPLAY: state_nx = CS_LOOK;
            default:   state_nx = CS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= state_nx;
    end

    // Capture the accepted address
    always_ff @(posedge clk) begin
        if (!rst_n)      held_addr <= '0;
        else if (accept) held_addr <= req_addr;
    end

    // Valid flags: cleared by reset, set when a fill is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q <= '0;
        else if (ack_pop) valid_q[tag_widx] <= 1'b1;
    end

endmodule

// File: rtl/rc_fill.sv
// Module rc_fill
// Fill engine. It takes one line address from the miss queue, reads the
// words of that line from external memory in ascending offset order with a
// request held until acknowledged, writes each word into the data RAM, and
// then pushes the line address into the acknowledge queue. Assumes external
// memory raises mem_ack only while mem_req is high.
module rc_fill
    import rc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int WORDS  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           miss_empty,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] miss_line,
    output logic                           miss_pop,
    output logic                           ack_push,
    output logic [ADDR_W-$clog2(WORDS)-1:0] ack_line,
    output logic                           mem_req,
    output logic [ADDR_W-1:0]              mem_addr,
    input  logic                           mem_ack,
    input  logic [DATA_W-1:0]              mem_rdata,
    output logic                           dram_we,
    output logic [$clog2(LINES*WORDS)-1:0] dram_waddr,
    output logic [DATA_W-1:0]              dram_wdata
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

    fill_state_t       fstate;
    logic [LINE_W-1:0] line_q;
    logic [OFF_W-1:0]  word_q;
    logic              last_word;

    // Memory request, RAM write and acknowledge generation
    always_comb begin
        miss_pop   = (fstate == FS_IDLE) && !miss_empty;
        mem_req    = (fstate == FS_RUN);
        mem_addr   = {line_q, word_q};
        last_word  = (word_q == LAST_OFF);
        dram_we    = mem_req && mem_ack;
        dram_waddr = {line_q[IDX_W-1:0], word_q};
        dram_wdata = mem_rdata;
        ack_push   = dram_we && last_word;
        ack_line   = line_q;
    end

    // Fill sequencing: load a line, step through its words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fstate <= FS_IDLE;
            line_q <= '0;
            word_q <= '0;
        end else begin
            unique case (fstate)
                FS_IDLE: begin
                    if (!miss_empty) begin
                        line_q <= miss_line;
                        word_q <= '0;
                        fstate <= FS_RUN;
                    end
                end
                FS_RUN: begin
                    if (mem_ack) begin
                        word_q <= word_q + 1'b1;
                        if (last_word) fstate <= FS_IDLE;
                    end
                end
                default: fstate <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ro_cache.sv
// Module ro_cache
// Direct-mapped read-only cache top. It joins the lookup controller, the data
// RAM, the two decoupling queues and the fill engine. Assumes word addressing,
// LINES and WORDS powers of two (each at least 2), and a single client that
// holds its request until accepted.
module ro_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int DWORDS = LINES * WORDS;
    localparam int DA_W   = $clog2(DWORDS);

    logic              miss_push, miss_pop, miss_empty, miss_full;
    logic [LINE_W-1:0] miss_in, miss_out;
    logic              ack_push, ack_pop, ack_empty, ack_full;
    logic [LINE_W-1:0] ack_in, ack_out;
    logic              dram_we;
    logic [DA_W-1:0]   dram_waddr, dram_raddr;
    logic [DATA_W-1:0] dram_wdata, dram_rdata;
    logic              unused_full;

    assign unused_full = miss_full | ack_full;

    // Lookup controller
    rc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .miss_push  (miss_push),
        .miss_line  (miss_in),
        .ack_empty  (ack_empty),
        .ack_line   (ack_out),
        .ack_pop    (ack_pop),
        .dram_raddr (dram_raddr),
        .dram_rdata (dram_rdata)
    );

    // Miss queue toward the fill engine
    rc_fifo #(.WIDTH(LINE_W), .DEPTH(2)) u_miss_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (miss_push),
        .din   (miss_in),
        .pop   (miss_pop),
        .dout  (miss_out),
        .empty (miss_empty),
        .full  (miss_full)
    );

    // Acknowledge queue back to the controller
    rc_fifo #(.WIDTH(LINE_W), .DEPTH(2)) u_ack_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ack_push),
        .din   (ack_in),
        .pop   (ack_pop),
        .dout  (ack_out),
        .empty (ack_empty),
        .full  (ack_full)
    );

    // Line data storage
    rc_ram #(.WIDTH(DATA_W), .DEPTH(DWORDS)) u_data_ram (
        .clk   (clk),
        .we    (dram_we),
        .waddr (dram_waddr),
        .wdata (dram_wdata),
        .raddr (dram_raddr),
        .rdata (dram_rdata)
    );

    // Fill engine
    rc_fill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_empty (miss_empty),
        .miss_line  (miss_out),
        .miss_pop   (miss_pop),
        .ack_push   (ack_push),
        .ack_line   (ack_in),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .dram_we    (dram_we),
        .dram_waddr (dram_waddr),
        .dram_wdata (dram_wdata)
    );

endmodule

// File: rtl/ro_cache_checker.sv
// Module ro_cache_checker
// Port-level protocol checks for ro_cache, attached by bind. Assumes the
// external memory acknowledges only a held request.
module ro_cache_checker #(
    parameter int ADDR_W = 12,
    parameter int WORDS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    localparam int OFF_W = $clog2(WORDS);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

    logic was_rst;

    // Remember that the previous edge was a reset edge
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: idle outputs in the first cycle after reset
    always_ff @(posedge clk) begin
        if (rst_n && was_rst)
            assert_reset_idle_R1: assert (req_ready && !rsp_valid && !mem_req)
                else $error("R1 outputs not idle after reset");
    end

    // R5: request held steady until acknowledged
    assert_mem_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5: within a line the next word follows the acknowledged one
    assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[OFF_W-1:0] != LAST_OFF))
        |=> (mem_req && (mem_addr == $past(mem_addr) + 1'b1)));

    // R5: a new line always starts at offset zero
    assert_line_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (mem_addr[OFF_W-1:0] == '0));

    // R8: external memory is used only while the client is stalled
    assert_single_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R4: no response while the controller is ready for a new request
    assert_no_rsp_when_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R10: response is a single-cycle pulse followed by ready
    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R3: an accepted request sees either a response or a stall next cycle
    assert_accept_leaves_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind ro_cache ro_cache_checker #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_ro_cache_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack)
);

// File: tb/ro_cache_bench.sv
// Bench for ro_cache: directed corner cases plus seeded random reads, checked
// against a bench-side tag model and a computed memory content function.
module ro_cache_bench;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LINES  = 8;
    localparam int WORDS  = 4;
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = ADDR_W - OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model of the cache contents
    bit               m_valid [LINES];
    logic [TAG_W-1:0] m_tag   [LINES];
    logic [LINE_W-1:0] cur_line = '0;
    int               fill_off = 0;

    always #10 clk = ~clk;  // 50 MHz

    ro_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_ro_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return (DATA_W'(a) * 32'h9E37_79B1) ^ 32'hA5C3_0F00;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // External memory model: acknowledges a held request after 0..3 cycles
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                if (dly == 0) begin
                    check(mem_addr == {cur_line, OFF_W'(fill_off)}, "R5", "fill word address",
                          mem_addr, {cur_line, OFF_W'(fill_off)});
                    fill_off = (fill_off + 1) % WORDS;
                    mem_ack   = 1'b1;
                    mem_rdata = mem_word(mem_addr);
                    dly = $urandom_range(0, 3);
                end else begin
                    dly--;
                end
            end
        end
    end

    // One client read, checked against the model (R2, R3, R4, R6, R7, R9, R10)
    task automatic do_read(input logic [ADDR_W-1:0] a, input string tagname);
        logic [IDX_W-1:0] idx = a[OFF_W +: IDX_W];
        logic [TAG_W-1:0] tg  = a[ADDR_W-1 -: TAG_W];
        bit exp_hit = m_valid[idx] && (m_tag[idx] == tg);
        int cyc = 0;
        bit stall_ok = 1'b1;
        cur_line = a[ADDR_W-1:OFF_W];
        fill_off = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && cyc < 1000) begin
            if (req_ready) stall_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        if (exp_hit)
            check(cyc == 0, "R3", {tagname, " hit latency (R2 split)"}, cyc, 0);
        else begin
            check(cyc >= WORDS, "R9", {tagname, " miss must wait for fill (R7)"}, cyc, WORDS);
            check(stall_ok, "R4", {tagname, " ready low during miss"}, stall_ok, 1);
        end
        check(rsp_data == mem_word(a), "R6", {tagname, " read data"}, rsp_data, mem_word(a));
        @(negedge clk);
        check(!rsp_valid && req_ready, "R10", {tagname, " single pulse then ready"},
              {rsp_valid, req_ready}, 2'b01);
        m_valid[idx] = 1'b1;
        m_tag[idx]   = tg;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    // Main sequence
    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < LINES; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i]   = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R1", "reset outputs",
              {req_ready, rsp_valid, mem_req}, 3'b100);

        // Directed corner cases
        do_read(12'h005, "cold");              // R9 first touch misses
        do_read(12'h006, "same line");         // R2 same tag/index hits
        do_read(12'h007, "last offset");
        do_read(12'h004, "first offset");
        do_read(12'h085, "conflict");          // R7 same index, other tag
        do_read(12'h005, "evicted");           // R7 old tag misses again
        do_read(12'h009, "next index");        // R2 different index misses
        do_read(12'hFFF, "top address");
        do_read(12'hFFC, "top line hit");

        // Seeded random reads over four tags
        for (int n = 0; n < 300; n++) begin
            logic [ADDR_W-1:0] a;
            a = {TAG_W'($urandom_range(0, 3)), IDX_W'($urandom), OFF_W'($urandom)};
            do_read(a, "random");
        end

        // Reset again clears all lines (R9)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LINES; i++) m_valid[i] = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R1", "second reset outputs",
              {req_ready, rsp_valid, mem_req}, 3'b100);
        do_read(12'h006, "after reset");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule